// File: doc/BRIEF.md
# FIFO Threshold Offset Loader

This block supplies the almost-empty and almost-full threshold offsets to a FIFO's flag logic. While the full reset is held, it samples a three-bit source select and a parity-mode input. These choose the offset source: one of five built-in offsets, serial programming through a one-bit data input, or parallel programming from the low bits of the write-port data bus. A single built-in value is applied to both thresholds.

When the source is programmable, the block collects the almost-empty offset first and the almost-full offset second. It then raises a done flag and freezes both values until the next full reset. Until the done flag is high, ordinary FIFO writes are gated off. A partial reset, which flushes the FIFO elsewhere, never disturbs the offsets, the source choice or loading progress. It only suppresses the write grant while it is asserted.

Top module: `ofs_cfg_loader`

## Requirements
- R1: When `fsel` is 3'b010, 3'b011, 3'b100, 3'b101 or 3'b110 during full reset, both `ae_ofs` and `af_ofs` take the values 8, 16, 64, 256 and 1024 respectively, and `cfg_done` is high in the first cycle after reset release.
- R2: When `fsel` is 3'b000 (serial) or 3'b001 or 3'b111 (parallel) during full reset, both offsets read zero and `cfg_done` is low after reset release.
- R3: In serial mode, each rising clock with `ser_en` high shifts one `ser_data` bit in. There are 2*OFS_W such bits: the almost-empty offset first, then the almost-full offset, each MSB first. Clocks with `ser_en` low shift nothing.
- R4: Both offsets and `cfg_done` update together on the clock edge that takes the last serial bit or the second parallel word. Before that edge `cfg_done` is low.
- R5: In parallel mode, the first clock with `wr_en` high loads the almost-empty offset and the second loads the almost-full offset. With `par_sel` low at reset, each value is `wr_data[OFS_W-1:0]`.
- R6: With `par_sel` high at reset, bit 8 of `wr_data` is dropped during parallel loading. The loaded value is `{wr_data[OFS_W:9], wr_data[7:0]}`.
- R7: Once `cfg_done` is high, further `ser_en`, `ser_data`, `wr_en` or `wr_data` activity leaves both offsets unchanged, and `cfg_done` stays high until the next full reset.
- R8: Holding `prst_n` low changes neither offset nor `cfg_done`, and does not lose serial loading progress made before it.
- R9: `wr_ok` is high exactly when `wr_en` is high, `cfg_done` is high and `prst_n` is high. Words used for parallel programming never produce `wr_ok`.
- R10: `fsel` and `par_sel` are sampled only while `rst_n` is low. Changing them afterwards has no effect on the offsets or the loading method.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Full reset, active low, synchronous; samples the selects |
| prst_n | input | 1 | Partial reset, active low; only blocks the write grant |
| fsel | input | 3 | Offset source select, sampled during full reset |
| par_sel | input | 1 | Interspersed-parity mode, sampled during full reset |
| ser_en | input | 1 | Serial shift enable |
| ser_data | input | 1 | Serial offset data bit |
| wr_en | input | 1 | Write enable of the FIFO write port |
| wr_data | input | OFS_W+1 | Low bits of the write-port data bus |
| ae_ofs | output | OFS_W | Almost-empty threshold offset |
| af_ofs | output | OFS_W | Almost-full threshold offset |
| cfg_done | output | 1 | Offsets are final |
| wr_ok | output | 1 | Normal FIFO write granted |

## Verification
Some properties are checked on every cycle. The done flag never drops outside full reset, and the offsets are frozen while it is high. A built-in source is always done. The serial bit counter stays within its range, and the parallel phase bit moves only on a qualified write.

Other behaviours only the bench scenarios can show. These are the bit ordering of the serial stream, the dropping of bit 8 under parity mode, the word order of parallel loading, and blocked writes during programming. They also include partial reset arriving in the middle of a serial load and select changes after reset. The bench covers these with directed cases and seeded random offsets.

// File: rtl/ofs_cfg_pkg.sv
`timescale 1ns/1ps
package ofs_cfg_pkg;
   typedef enum logic [1:0] {SRC_DEF, SRC_SER, SRC_PAR} src_e;

   function automatic int unsigned builtin_offset(input logic [2:0] sel);
      case (sel)
         3'b010:  return 8;
         3'b011:  return 16;
         3'b100:  return 64;
         3'b101:  return 256;
         3'b110:  return 1024;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/ofs_src_decode.sv
`timescale 1ns/1ps
module ofs_src_decode
   import ofs_cfg_pkg::*;
#(
   parameter int OFS_W = 13
) (
   input  logic [2:0]       fsel,
   output src_e             src,
   output logic [OFS_W-1:0] def_val
);
   always_comb begin
      case (fsel)
         3'b000:         src = SRC_SER;
         3'b001, 3'b111: src = SRC_PAR;
         default:        src = SRC_DEF;
      endcase
      def_val = OFS_W'(builtin_offset(fsel));
   end
endmodule

// File: rtl/ofs_serial_loader.sv
`timescale 1ns/1ps
module ofs_serial_loader #(
   parameter int OFS_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             sdata,
   output logic             fin,
   output logic [OFS_W-1:0] ae_val,
   output logic [OFS_W-1:0] af_val
);
   localparam int TOT = 2 * OFS_W;
   localparam int CW  = $clog2(TOT + 1);

   logic [CW-1:0]  cnt;
   logic [TOT-2:0] sh;
   logic [TOT-1:0] nxt;

   assign nxt    = {sh, sdata};
   assign fin    = go && (cnt == CW'(TOT - 1));
   assign ae_val = nxt[TOT-1:OFS_W];
   assign af_val = nxt[OFS_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         sh  <= '0;
      end else if (go) begin
         sh  <= nxt[TOT-2:0];
         cnt <= cnt + 1'b1;
      end
   end

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(TOT));
endmodule

// File: rtl/ofs_par_loader.sv
`timescale 1ns/1ps
module ofs_par_loader #(
   parameter int OFS_W      = 13,
   parameter int PAR_POS    = 8,
   parameter bit PARITY_OPT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             par_on,
   input  logic [OFS_W:0]   data,
   output logic             fin,
   output logic [OFS_W-1:0] ae_val,
   output logic [OFS_W-1:0] af_val
);
   logic             phase;
   logic [OFS_W-1:0] ae_hold;
   logic [OFS_W-1:0] val;

   generate
      if (PARITY_OPT) begin : g_parity
         always_comb
            val = par_on ? {data[OFS_W:PAR_POS+1], data[PAR_POS-1:0]}
                         : data[OFS_W-1:0];
      end else begin : g_plain
         always_comb val = data[OFS_W-1:0];
      end
   endgenerate

   assign fin    = go && phase;
   assign ae_val = ae_hold;
   assign af_val = val;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= 1'b0;
         ae_hold <= '0;
      end else if (go) begin
         phase <= ~phase;
         if (!phase) ae_hold <= val;
      end
   end

   // R5
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !go |=> $stable(phase));
endmodule

// File: rtl/ofs_cfg_loader.sv
`timescale 1ns/1ps
module ofs_cfg_loader
   import ofs_cfg_pkg::*;
#(
   parameter int OFS_W      = 13,
   parameter int PAR_POS    = 8,
   parameter bit PARITY_OPT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             prst_n,
   input  logic [2:0]       fsel,
   input  logic             par_sel,
   input  logic             ser_en,
   input  logic             ser_data,
   input  logic             wr_en,
   input  logic [OFS_W:0]   wr_data,
   output logic [OFS_W-1:0] ae_ofs,
   output logic [OFS_W-1:0] af_ofs,
   output logic             cfg_done,
   output logic             wr_ok
);
   if (OFS_W < 11 || OFS_W > 24) begin : g_bad_width
      $error("OFS_W must hold 1024 and stay below 25 bits");
   end
   if (PAR_POS < 1 || PAR_POS >= OFS_W) begin : g_bad_parity
      $error("PAR_POS must lie inside the offset field");
   end

   src_e             src_d, src_q;
   logic [OFS_W-1:0] def_val;
   logic             par_q;
   logic             ser_go, par_go, ser_fin, par_fin;
   logic [OFS_W-1:0] ser_ae, ser_af, par_ae, par_af;

   ofs_src_decode #(.OFS_W(OFS_W)) i_dec (
      .fsel(fsel), .src(src_d), .def_val(def_val));

   assign ser_go = (src_q == SRC_SER) && !cfg_done && ser_en;
   assign par_go = (src_q == SRC_PAR) && !cfg_done && wr_en;

   ofs_serial_loader #(.OFS_W(OFS_W)) i_ser (
      .clk(clk), .rst_n(rst_n), .go(ser_go), .sdata(ser_data),
      .fin(ser_fin), .ae_val(ser_ae), .af_val(ser_af));

   ofs_par_loader #(.OFS_W(OFS_W), .PAR_POS(PAR_POS), .PARITY_OPT(PARITY_OPT)) i_par (
      .clk(clk), .rst_n(rst_n), .go(par_go), .par_on(par_q), .data(wr_data),
      .fin(par_fin), .ae_val(par_ae), .af_val(par_af));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q    <= src_d;
         par_q    <= par_sel;
         cfg_done <= (src_d == SRC_DEF);
         ae_ofs   <= def_val;
         af_ofs   <= def_val;
      end else if (ser_fin) begin
         ae_ofs   <= ser_ae;
         af_ofs   <= ser_af;
         cfg_done <= 1'b1;
      end else if (par_fin) begin
         ae_ofs   <= par_ae;
         af_ofs   <= par_af;
         cfg_done <= 1'b1;
      end
   end

   assign wr_ok = wr_en && cfg_done && prst_n;

   // R7
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |=> cfg_done);
   // R7
   ofs_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |=> ($stable(ae_ofs) && $stable(af_ofs)));
   // R1
   def_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q == SRC_DEF) |-> cfg_done);
   // R3
   single_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ser_fin && par_fin));
endmodule

// File: tb/test_ofs_cfg_loader.sv
`timescale 1ns/1ps
module test_ofs_cfg_loader;
   localparam int W = 13;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0, prst_n = 1'b1;
   logic [2:0]   fsel = 3'b010;
   logic         par_sel = 1'b0, ser_en = 1'b0, ser_data = 1'b0, wr_en = 1'b0;
   logic [W:0]   wr_data = '0;
   logic [W-1:0] ae_ofs, af_ofs;
   logic         cfg_done, wr_ok;

   int n_chk = 0, n_err = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   ofs_cfg_loader i_ofs_cfg_loader (
      .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .fsel(fsel), .par_sel(par_sel),
      .ser_en(ser_en), .ser_data(ser_data), .wr_en(wr_en), .wr_data(wr_data),
      .ae_ofs(ae_ofs), .af_ofs(af_ofs), .cfg_done(cfg_done), .wr_ok(wr_ok));

   function automatic logic [W-1:0] exp_def(input logic [2:0] s);
      case (s)
         3'b010: return 8;    3'b011: return 16;  3'b100: return 64;
         3'b101: return 256;  3'b110: return 1024;
         default: return 0;
      endcase
   endfunction

   function automatic logic [W-1:0] exp_pack(input logic [W:0] d, input logic par);
      return par ? {d[W:9], d[7:0]} : d[W-1:0];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   task automatic full_reset(input logic [2:0] s, input logic par);
      @(negedge clk);
      rst_n = 1'b0; fsel = s; par_sel = par; ser_en = 0; wr_en = 0; prst_n = 1;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      // R10: selects move after reset, must be ignored
      fsel = 3'($urandom); par_sel = 1'($urandom);
   endtask

   task automatic serial_load(input logic [W-1:0] ae, input logic [W-1:0] af, input bit gaps);
      logic [2*W-1:0] bits = {ae, af};
      for (int i = 2*W-1; i >= 0; i--) begin
         if (gaps && ($urandom % 3 == 0)) begin
            ser_en = 0; ser_data = 1'($urandom); wr_en = 1;
            #1 chk("R9 write blocked while programming", wr_ok, 0);
            @(negedge clk);
         end
         if (gaps && i == W && ($urandom % 2 == 0)) begin
            ser_en = 0; wr_en = 0; prst_n = 0;
            @(negedge clk);
            chk("R8 partial reset keeps done low", cfg_done, 0);
            prst_n = 1;
         end
         wr_en = 0; ser_en = 1; ser_data = bits[i];
         if (i == 0) chk("R4 done low before last bit", cfg_done, 0);
         @(negedge clk);
      end
      ser_en = 0;
      chk("R4 serial done", cfg_done, 1);
      chk("R3 serial ae", ae_ofs, ae);
      chk("R3 serial af", af_ofs, af);
   endtask

   task automatic parallel_load(input logic [W:0] w0, input logic [W:0] w1, input logic par);
      if ($urandom % 2) begin wr_en = 0; @(negedge clk); end
      wr_en = 1; wr_data = w0;
      #1 chk("R9 config word not a write", wr_ok, 0);
      @(negedge clk);
      chk("R4 done low after first word", cfg_done, 0);
      wr_en = 0; wr_data = '1;
      @(negedge clk);
      wr_en = 1; wr_data = w1;
      @(negedge clk);
      wr_en = 0;
      chk("R4 parallel done", cfg_done, 1);
      chk(par ? "R6 parity ae" : "R5 parallel ae", ae_ofs, exp_pack(w0, par));
      chk(par ? "R6 parity af" : "R5 parallel af", af_ofs, exp_pack(w1, par));
   endtask

   task automatic after_done(input logic [W-1:0] ae, input logic [W-1:0] af);
      for (int k = 0; k < 4; k++) begin
         ser_en = 1; ser_data = 1'($urandom); wr_en = 1; wr_data = 14'($urandom);
         #1 chk("R9 write granted when done", wr_ok, 1);
         @(negedge clk);
      end
      ser_en = 0; wr_en = 0;
      chk("R7 ae frozen", ae_ofs, ae);
      chk("R7 af frozen", af_ofs, af);
      prst_n = 0; wr_en = 1;
      #1 chk("R9 write blocked in partial reset", wr_ok, 0);
      @(negedge clk); @(negedge clk);
      chk("R8 ae kept", ae_ofs, ae);
      chk("R8 af kept", af_ofs, af);
      chk("R8 done kept", cfg_done, 1);
      prst_n = 1; wr_en = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      int unsigned seed_init;
      logic [W-1:0] a, b;
      logic [W:0] d0, d1;
      seed_init = $urandom(32'd20240611);
      // R1: every built-in offset
      for (int s = 2; s <= 6; s++) begin
         full_reset(3'(s), 0);
         chk("R1 default done", cfg_done, 1);
         chk("R1 default ae", ae_ofs, exp_def(3'(s)));
         chk("R1 default af", af_ofs, exp_def(3'(s)));
         after_done(exp_def(3'(s)), exp_def(3'(s)));
      end
      // R2 reset state of programmable sources
      full_reset(3'b000, 0);
      chk("R2 serial not done", cfg_done, 0);
      chk("R2 serial ae zero", ae_ofs, 0);
      chk("R2 serial af zero", af_ofs, 0);
      serial_load(13'h1ABC, 13'h0001, 0);
      after_done(13'h1ABC, 13'h0001);
      full_reset(3'b111, 0);
      chk("R2 parallel not done", cfg_done, 0);
      chk("R10 stale select ignored", ae_ofs, 0);
      // R6 corner: only bit 8 set
      parallel_load(14'h0100, 14'h3FFF, 0);
      full_reset(3'b001, 1);
      parallel_load(14'h0100, 14'h3EFF, 1);
      after_done(exp_pack(14'h0100, 1), exp_pack(14'h3EFF, 1));
      // random mix
      for (int it = 0; it < 40; it++) begin
         case ($urandom % 3)
            0: begin
               a = 13'($urandom); b = 13'($urandom);
               full_reset(3'b000, 1'($urandom));
               serial_load(a, b, 1);
               after_done(a, b);
            end
            1: begin
               logic p = 1'($urandom);
               d0 = 14'($urandom); d1 = 14'($urandom);
               full_reset(($urandom % 2) ? 3'b001 : 3'b111, p);
               parallel_load(d0, d1, p);
               after_done(exp_pack(d0, p), exp_pack(d1, p));
            end
            default: begin
               logic [2:0] s = 3'(2 + $urandom % 5);
               full_reset(s, 1'($urandom));
               chk("R1 random default", ae_ofs, exp_def(s));
               chk("R10 default kept", af_ofs, exp_def(s));
            end
         endcase
      end
      finished = 1;
      summary();
      $finish;
   end
endmodule